// File: doc/BRIEF.md
# PWM Fault Input Blanking Unit

This unit keeps a protection input and a current-limit input from reacting to switching noise around a complementary PWM pair. It watches the high-side output, the low-side output and one auxiliary blanking signal. From these it builds a blanking condition that is applied to the two inputs, and it hands the filtered versions to the fault-handling logic downstream.

Two mechanisms are combined with a logical OR. The first is edge-triggered. Any of the four PWM transitions (high-side rising or falling, low-side rising or falling) can be allowed to start a countdown. The countdown is loaded from a blanking-delay register, and it masks the inputs for that many clock cycles. A new allowed edge that arrives while a countdown is running starts it again. The second mechanism is level-based. It masks the inputs for as long as a chosen signal holds a chosen level. The candidates are the auxiliary signal high, the auxiliary signal low, and each of the two PWM outputs high or low.

Each input has its own enable. An input whose enable is clear passes through untouched. Software programs the unit through a single-cycle write port, and it reads either register back through a combinational read mux.

Top module: `fault_blanker`

## Requirements
- R1: After reset, both registers read 0, and `faultOut`/`curLimOut` equal `faultIn`/`curLimIn`.
- R2: A write with `regAddr`=0 updates the control register, and bits 9 to 6 always read 0. A write with `regAddr`=1 updates the delay register, which is `DELAY_W` bits wide and is zero-extended on readback.
- R3: Control bit 15 enables the high-side rising edge, bit 14 the high-side falling edge, bit 13 the low-side rising edge and bit 12 the low-side falling edge. An enabled edge masks the enabled inputs for exactly D cycles, where D is the delay register value. The first masked cycle is the cycle in which the new PWM level is present at the input.
- R4: A PWM edge whose enable bit is clear produces no masking.
- R5: An enabled edge that arrives while blanking is active restarts the count, so masking lasts D cycles from the last edge.
- R6: With D = 0, enabled edges add no masking.
- R7: Control bit 11 enables blanking of `faultIn` and bit 10 enables blanking of `curLimIn`. An input whose enable is clear equals its output at all times.
- R8: Control bit 5 masks the enabled inputs while `blankSig` is 1, and bit 4 masks them while `blankSig` is 0.
- R9: Control bit 3 masks while `pwmHigh` is 1, bit 2 while `pwmHigh` is 0, bit 1 while `pwmLow` is 1, and bit 0 while `pwmLow` is 0.
- R10: A filtered output is 1 only when its raw input is 1 and no blanking applies to it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe |
| regAddr | input | 1 | Register select: 0 control, 1 delay |
| regWdata | input | 16 | Write data |
| regRdata | output | 16 | Readback of the selected register |
| pwmHigh | input | 1 | High-side PWM output being observed |
| pwmLow | input | 1 | Low-side PWM output being observed |
| blankSig | input | 1 | Auxiliary blanking signal |
| faultIn | input | 1 | Raw fault input |
| curLimIn | input | 1 | Raw current-limit input |
| faultOut | output | 1 | Filtered fault input |
| curLimOut | output | 1 | Filtered current-limit input |

## Verification
The embedded properties check the following on every cycle:
- The countdown only decrements or stays at zero when no reload occurs.
- A filtered output never rises without its raw input.
- A disabled input always passes straight through.
- The unimplemented control bits read as zero, and delay writes land.

The exact window length and its alignment to the PWM transition can only be shown by the directed scenarios. The same holds for the restart on a late edge, the behaviour with a zero delay, and the mapping of each edge and level enable to its bit.

// File: rtl/fault_blanker_pkg.sv
package fault_blanker_pkg;

  localparam int CTRL_W = 16;

  localparam int BIT_HI_RISE = 15;
  localparam int BIT_HI_FALL = 14;
  localparam int BIT_LO_RISE = 13;
  localparam int BIT_LO_FALL = 12;
  localparam int BIT_EN_FLT  = 11;
  localparam int BIT_EN_CL   = 10;
  localparam int BIT_AUX_HI  = 5;
  localparam int BIT_AUX_LO  = 4;
  localparam int BIT_HH      = 3;
  localparam int BIT_HL      = 2;
  localparam int BIT_LH      = 1;
  localparam int BIT_LL      = 0;

  localparam logic [CTRL_W-1:0] CTRL_IMPL_MASK = 16'hFC3F;

  typedef struct packed {
    logic edgeHit;
    logic stateHit;
    logic enCurLim;
    logic enFault;
  } blankStrobes_t;

endpackage

// File: rtl/fault_blanker_ctrl.sv
module fault_blanker_ctrl
  import fault_blanker_pkg::*;
#(
  parameter int DELAY_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWe,
  input  logic               regAddr,
  input  logic [CTRL_W-1:0]  regWdata,
  output logic [CTRL_W-1:0]  regRdata,
  input  logic               pwmHigh,
  input  logic               pwmLow,
  input  logic               blankSig,
  output blankStrobes_t      strb,
  output logic [DELAY_W-1:0] delayVal
);

  localparam int NUM_PWM = 2;

  logic [CTRL_W-1:0]  ctrlReg;
  logic [DELAY_W-1:0] delayReg;
  logic [NUM_PWM-1:0] pwmNow;
  logic [NUM_PWM-1:0] pwmPrev;
  logic [NUM_PWM-1:0] riseEn;
  logic [NUM_PWM-1:0] fallEn;
  logic [NUM_PWM-1:0] riseSeen;
  logic [NUM_PWM-1:0] fallSeen;
  logic               levelHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      delayReg <= '0;
    end else if (regWe) begin
      if (regAddr) delayReg <= regWdata[DELAY_W-1:0];
      else         ctrlReg  <= regWdata & CTRL_IMPL_MASK;
    end
  end

  assign regRdata = regAddr ? CTRL_W'(delayReg) : ctrlReg;
  assign delayVal = delayReg;

  // index 0 = high side, index 1 = low side
  assign pwmNow = {pwmLow, pwmHigh};
  assign riseEn = {ctrlReg[BIT_LO_RISE], ctrlReg[BIT_HI_RISE]};
  assign fallEn = {ctrlReg[BIT_LO_FALL], ctrlReg[BIT_HI_FALL]};

  always_ff @(posedge clk) begin
    if (!rstN) pwmPrev <= '0;
    else       pwmPrev <= pwmNow;
  end

  for (genvar gi = 0; gi < NUM_PWM; gi++) begin : g_edge
    assign riseSeen[gi] = pwmNow[gi] & ~pwmPrev[gi] & riseEn[gi];
    assign fallSeen[gi] = ~pwmNow[gi] & pwmPrev[gi] & fallEn[gi];
  end

  always_comb begin
    levelHit = (ctrlReg[BIT_AUX_HI] &  blankSig) |
               (ctrlReg[BIT_AUX_LO] & ~blankSig) |
               (ctrlReg[BIT_HH]     &  pwmHigh)  |
               (ctrlReg[BIT_HL]     & ~pwmHigh)  |
               (ctrlReg[BIT_LH]     &  pwmLow)   |
               (ctrlReg[BIT_LL]     & ~pwmLow);
  end

  always_comb begin
    strb.edgeHit  = |{riseSeen, fallSeen};
    strb.stateHit = levelHit;
    strb.enFault  = ctrlReg[BIT_EN_FLT];
    strb.enCurLim = ctrlReg[BIT_EN_CL];
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !regAddr |-> regRdata[9:6] == 4'b0000); // R2

  AST_DELAY_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (regWe && regAddr) |=> delayVal == $past(regWdata[DELAY_W-1:0])); // R2

endmodule

// File: rtl/fault_blanker_datapath.sv
module fault_blanker_datapath
  import fault_blanker_pkg::*;
#(
  parameter int DELAY_W = 8,
  parameter int NUM_IN  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  blankStrobes_t      strb,
  input  logic [DELAY_W-1:0] delayVal,
  input  logic [NUM_IN-1:0]  rawIn,
  output logic [NUM_IN-1:0]  cleanIn
);

  localparam logic [DELAY_W-1:0] ONE = DELAY_W'(1);

  logic [DELAY_W-1:0] cnt;
  logic               reload;
  logic               edgeActive;
  logic               blankNow;
  logic [NUM_IN-1:0]  inEn;

  assign reload     = strb.edgeHit && (delayVal != '0);
  assign edgeActive = reload || (cnt != '0);
  assign blankNow   = edgeActive || strb.stateHit;
  assign inEn       = NUM_IN'({strb.enCurLim, strb.enFault});

  // The edge cycle itself is the first masked cycle, so load D-1
  always_ff @(posedge clk) begin
    if (!rstN)            cnt <= '0;
    else if (reload)      cnt <= delayVal - ONE;
    else if (cnt != '0)   cnt <= cnt - ONE;
  end

  for (genvar gi = 0; gi < NUM_IN; gi++) begin : g_mask
    assign cleanIn[gi] = rawIn[gi] & ~(inEn[gi] & blankNow);

    AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (!rstN)
      cleanIn[gi] |-> rawIn[gi]); // R10

    AST_PASS_WHEN_OFF: assert property (@(posedge clk) disable iff (!rstN)
      !inEn[gi] |-> cleanIn[gi] == rawIn[gi]); // R7
  end

  AST_CNT_DECAY: assert property (@(posedge clk) disable iff (!rstN)
    (!reload && cnt != '0) |=> cnt == $past(cnt) - ONE); // R3

  AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (!reload && cnt == '0) |=> cnt == '0); // R4

endmodule

// File: rtl/fault_blanker.sv
module fault_blanker
  import fault_blanker_pkg::*;
#(
  parameter int DELAY_W = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWe,
  input  logic        regAddr,
  input  logic [15:0] regWdata,
  output logic [15:0] regRdata,
  input  logic        pwmHigh,
  input  logic        pwmLow,
  input  logic        blankSig,
  input  logic        faultIn,
  input  logic        curLimIn,
  output logic        faultOut,
  output logic        curLimOut
);

  blankStrobes_t      strb;
  logic [DELAY_W-1:0] delayVal;
  logic [1:0]         cleanIn;

  fault_blanker_ctrl #(.DELAY_W(DELAY_W)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .regWe    (regWe),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .regRdata (regRdata),
    .pwmHigh  (pwmHigh),
    .pwmLow   (pwmLow),
    .blankSig (blankSig),
    .strb     (strb),
    .delayVal (delayVal)
  );

  fault_blanker_datapath #(.DELAY_W(DELAY_W), .NUM_IN(2)) uPath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .delayVal (delayVal),
    .rawIn    ({curLimIn, faultIn}),
    .cleanIn  (cleanIn)
  );

  assign faultOut  = cleanIn[0];
  assign curLimOut = cleanIn[1];

endmodule

// File: tb/tb_fault_blanker.sv
module tb_fault_blanker;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWe = 1'b0;
  logic        regAddr = 1'b0;
  logic [15:0] regWdata = '0;
  logic [15:0] regRdata;
  logic        pwmHigh = 1'b0;
  logic        pwmLow = 1'b0;
  logic        blankSig = 1'b0;
  logic        faultIn = 1'b1;
  logic        curLimIn = 1'b1;
  logic        faultOut;
  logic        curLimOut;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  fault_blanker dut (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .pwmHigh(pwmHigh),
    .pwmLow(pwmLow), .blankSig(blankSig), .faultIn(faultIn),
    .curLimIn(curLimIn), .faultOut(faultOut), .curLimOut(curLimOut)
  );

  always #5 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic addr, input logic [15:0] data);
    @(negedge clk);
    regWe = 1'b1; regAddr = addr; regWdata = data;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic readReg(input logic addr, output logic [15:0] data);
    @(negedge clk);
    regAddr = addr;
    #1 data = regRdata;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  // Drive one PWM to a level at a falling clock edge, then count the
  // consecutive cycles with faultOut masked (faultIn held at 1).
  task automatic toggleMeasure(input bit lowSide, input logic lvl, output int n);
    @(negedge clk);
    if (lowSide) pwmLow = lvl; else pwmHigh = lvl;
    n = 0;
    #1;
    while (faultOut == 1'b0 && n < 40) begin
      n++;
      @(negedge clk); #1;
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    readReg(1'b0, v); check("R1 ctrl reset", v, 0);
    readReg(1'b1, v); check("R1 delay reset", v, 0);
    faultIn = 1'b1; curLimIn = 1'b0; #1;
    check("R1 fault pass", faultOut, 1);
    check("R1 curlim pass", curLimOut, 0);
    curLimIn = 1'b1; #1;
    check("R1 curlim pass hi", curLimOut, 1);
  endtask

  task automatic t_readback();
    logic [15:0] v;
    writeReg(1'b0, 16'hFFFF);
    readReg(1'b0, v); check("R2 ctrl rsvd", v, 16'hFC3F);
    writeReg(1'b0, 16'h0000);
    writeReg(1'b1, 16'h0005);
    readReg(1'b1, v); check("R2 delay", v, 5);
    readReg(1'b0, v); check("R2 ctrl cleared", v, 0);
  endtask

  task automatic t_edges();
    int n;
    writeReg(1'b1, 16'd4);
    // R3 high-side rising, bit 15
    writeReg(1'b0, 16'h8800); settle();
    toggleMeasure(1'b0, 1'b1, n); check("R3 hi rise window", n, 4);
    // R4 high-side falling disabled
    settle(); toggleMeasure(1'b0, 1'b0, n); check("R4 hi fall off", n, 0);
    // R3 high-side falling, bit 14
    writeReg(1'b0, 16'h4800); settle();
    toggleMeasure(1'b0, 1'b1, n); check("R4 hi rise off", n, 0);
    settle(); toggleMeasure(1'b0, 1'b0, n); check("R3 hi fall window", n, 4);
    // R3 low-side rising, bit 13
    writeReg(1'b0, 16'h2800); settle();
    toggleMeasure(1'b1, 1'b1, n); check("R3 lo rise window", n, 4);
    settle(); toggleMeasure(1'b1, 1'b0, n); check("R4 lo fall off", n, 0);
    // R3 low-side falling, bit 12
    writeReg(1'b0, 16'h1800); settle();
    toggleMeasure(1'b1, 1'b1, n); check("R4 lo rise off", n, 0);
    settle(); toggleMeasure(1'b1, 1'b0, n); check("R3 lo fall window", n, 4);
    // R4 all edges disabled, fault blanking enabled
    writeReg(1'b0, 16'h0800); settle();
    toggleMeasure(1'b0, 1'b1, n); check("R4 none hi", n, 0);
    toggleMeasure(1'b0, 1'b0, n); check("R4 none hi fall", n, 0);
    // R3 longer delay
    writeReg(1'b1, 16'd9);
    writeReg(1'b0, 16'h8800); settle();
    toggleMeasure(1'b0, 1'b1, n); check("R3 window 9", n, 9);
    settle(); pwmHigh = 1'b0; settle();
  endtask

  task automatic t_restart();
    int n;
    writeReg(1'b1, 16'd4);
    writeReg(1'b0, 16'hC800); settle();
    @(negedge clk); pwmHigh = 1'b1; #1;
    check("R5 first edge masks", faultOut, 0);
    @(negedge clk); #1;
    check("R5 still masked", faultOut, 0);
    toggleMeasure(1'b0, 1'b0, n);
    check("R5 restart window", n, 4);
    settle();
  endtask

  task automatic t_zero();
    int n;
    writeReg(1'b1, 16'd0);
    writeReg(1'b0, 16'hFC00); settle();
    toggleMeasure(1'b0, 1'b1, n); check("R6 zero hi rise", n, 0);
    toggleMeasure(1'b1, 1'b1, n); check("R6 zero lo rise", n, 0);
    toggleMeasure(1'b0, 1'b0, n); check("R6 zero hi fall", n, 0);
    toggleMeasure(1'b1, 1'b0, n); check("R6 zero lo fall", n, 0);
  endtask

  task automatic t_inputEn();
    writeReg(1'b1, 16'd4);
    writeReg(1'b0, 16'h8800); settle();
    @(negedge clk); pwmHigh = 1'b1; #1;
    check("R7 fault masked", faultOut, 0);
    check("R7 curlim unblanked", curLimOut, 1);
    settle(); pwmHigh = 1'b0; settle();
    // current-limit only, level blanking on high-side high
    writeReg(1'b0, 16'h0408);
    @(negedge clk); pwmHigh = 1'b1; #1;
    check("R7 curlim masked", curLimOut, 0);
    check("R7 fault unblanked", faultOut, 1);
    pwmHigh = 1'b0; #1;
  endtask

  task automatic t_aux();
    writeReg(1'b0, 16'h0820);
    @(negedge clk); blankSig = 1'b1; #1; check("R8 aux hi masked", faultOut, 0);
    @(negedge clk); blankSig = 1'b0; #1; check("R8 aux hi clear", faultOut, 1);
    writeReg(1'b0, 16'h0810);
    @(negedge clk); #1; check("R8 aux lo masked", faultOut, 0);
    @(negedge clk); blankSig = 1'b1; #1; check("R8 aux lo clear", faultOut, 1);
    blankSig = 1'b0;
  endtask

  task automatic t_levels();
    writeReg(1'b0, 16'h0808);
    @(negedge clk); pwmHigh = 1'b1; #1; check("R9 HH masked", faultOut, 0);
    @(negedge clk); pwmHigh = 1'b0; #1; check("R9 HH clear", faultOut, 1);
    writeReg(1'b0, 16'h0804);
    @(negedge clk); #1; check("R9 HL masked", faultOut, 0);
    @(negedge clk); pwmHigh = 1'b1; #1; check("R9 HL clear", faultOut, 1);
    @(negedge clk); pwmHigh = 1'b0;
    writeReg(1'b0, 16'h0802);
    @(negedge clk); pwmLow = 1'b1; #1; check("R9 LH masked", faultOut, 0);
    @(negedge clk); pwmLow = 1'b0; #1; check("R9 LH clear", faultOut, 1);
    writeReg(1'b0, 16'h0801);
    @(negedge clk); #1; check("R9 LL masked", faultOut, 0);
    @(negedge clk); pwmLow = 1'b1; #1; check("R9 LL clear", faultOut, 1);
    @(negedge clk); pwmLow = 1'b0;
  endtask

  task automatic t_and();
    writeReg(1'b0, 16'h0C00); settle();
    @(negedge clk); faultIn = 1'b0; curLimIn = 1'b0; #1;
    check("R10 fault low", faultOut, 0);
    check("R10 curlim low", curLimOut, 0);
    writeReg(1'b0, 16'h0C20);
    @(negedge clk); blankSig = 1'b1; #1;
    check("R10 low while masked", faultOut, 0);
    faultIn = 1'b1; #1;
    check("R10 high while masked", faultOut, 0);
    @(negedge clk); blankSig = 1'b0; #1;
    check("R10 high unmasked", faultOut, 1);
    curLimIn = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_readback();
    t_edges();
    t_restart();
    t_zero();
    t_inputEn();
    t_aux();
    t_levels();
    t_and();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule